// File: doc/BRIEF.md
# Shadowed Single-Channel PWM Generator

This block produces one pulse-width-modulated output from an up-counter that runs from zero to a programmed period value and then wraps. A compare value sets how many cycles of each period the output spends in its asserted level, and a polarity bit picks whether that asserted level is high or low. Software programs the block through a small memory-mapped port with write strobes and registered read data.

Two copies of the period and compare settings exist. The live copy drives the waveform and can be written directly, which is the normal path while the output is stopped. The staged copy can be written at any time. It is only moved into the live copy when the counter wraps, so a change made while the output runs never cuts a period short or stretches it. A control word starts and stops the counter, enables the waveform (when disabled the output is held low), selects polarity, and keeps a two-bit field that disables synchronisation.

Top module: `apwm_shadow_gen`

## Requirements
- R1: After reset every register reads zero, the counter is stopped and `pwm_out` is low.
- R2: The register map uses these byte offsets: live period 0x08, live compare 0x0C, staged period 0x10, staged compare 0x14, control 0x2A (low 16 bits of the data word). Read data appears on `reg_rdata` on the clock edge that follows a read request. An unmapped offset reads zero.
- R3: With control bit 4 set the counter counts 0, 1, ... P and then returns to 0, so one waveform period lasts P+1 clock cycles.
- R4: With control bit 4 clear the counter holds its value, and the output does not toggle.
- R5: With control bit 9 set and bit 10 clear, the output is high for the first C cycles of each period (C = live compare) and low for the rest.
- R6: With control bits 9 and 10 both set, the output is low for the first C cycles of each period and high for the rest.
- R7: With control bit 9 clear, the output is low one cycle later whatever the polarity.
- R8: Under normal polarity a compare of 0 gives a constant low level, and a compare above the period gives a constant high level.
- R9: Writes to the staged period or compare leave the live values unchanged until the counter wraps. At that wrap both staged values are copied into the live registers.
- R10: A wrap with no staged write since the previous transfer leaves the live values as they are. This includes values written directly after that transfer.
- R11: A write to the live period or compare takes effect at the next clock edge, including while the counter runs.
- R12: Control bits 7:6 are stored and read back but do not change the waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| pwm_out | output | 1 | PWM waveform |

## Verification
A stale live register or a transfer made at the wrong moment changes the number of asserted cycles in the very next period. A window that spans a whole number of periods therefore shows it as a wrong high-cycle count within one period. The live registers can be read back, so a transfer that was lost or repeated appears at the port as soon as the counter has wrapped. A counter that keeps running while stopped shows up as toggles on `pwm_out` within one period. A mode bit that is ignored shows as any high cycle one clock after the bit clears.

// File: rtl/apwm_pkg.sv
package apwm_pkg;
  localparam int OFS_PRD_LIVE  = 'h08;
  localparam int OFS_CMP_LIVE  = 'h0C;
  localparam int OFS_PRD_STAGE = 'h10;
  localparam int OFS_CMP_STAGE = 'h14;
  localparam int OFS_CONTROL   = 'h2A;

  localparam int CB_RUN     = 4;
  localparam int CB_SYNC_LO = 6;
  localparam int CB_SYNC_HI = 7;
  localparam int CB_MODE    = 9;
  localparam int CB_POL_LOW = 10;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PRD_LIVE,
    SEL_CMP_LIVE,
    SEL_PRD_STAGE,
    SEL_CMP_STAGE,
    SEL_CONTROL
  } reg_sel_e;

  function automatic reg_sel_e decode_offset(input logic [15:0] ofs);
    case (int'(ofs))
      OFS_PRD_LIVE:  return SEL_PRD_LIVE;
      OFS_CMP_LIVE:  return SEL_CMP_LIVE;
      OFS_PRD_STAGE: return SEL_PRD_STAGE;
      OFS_CMP_STAGE: return SEL_CMP_STAGE;
      OFS_CONTROL:   return SEL_CONTROL;
      default:       return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/apwm_regs.sv
module apwm_regs import apwm_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CTRL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              wrap,
  output logic [DATA_W-1:0] prd_live,
  output logic [DATA_W-1:0] cmp_live,
  output logic [CTRL_W-1:0] ctrl,
  output logic              pend,
  output logic              stage_load
);
  logic [DATA_W-1:0] prd_stage, cmp_stage;
  reg_sel_e          sel;
  logic              wr_en, rd_en, stage_wr;
  logic [DATA_W-1:0] rd_mux;

  assign sel        = decode_offset(16'(reg_addr));
  assign wr_en      = reg_valid && reg_write;
  assign rd_en      = reg_valid && !reg_write;
  assign stage_wr   = wr_en && (sel == SEL_PRD_STAGE || sel == SEL_CMP_STAGE);
  assign stage_load = wrap && pend;

  always_comb begin
    case (sel)
      SEL_PRD_LIVE:  rd_mux = prd_live;
      SEL_CMP_LIVE:  rd_mux = cmp_live;
      SEL_PRD_STAGE: rd_mux = prd_stage;
      SEL_CMP_STAGE: rd_mux = cmp_stage;
      SEL_CONTROL:   rd_mux = DATA_W'(ctrl);
      default:       rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prd_live  <= '0;
      cmp_live  <= '0;
      prd_stage <= '0;
      cmp_stage <= '0;
      ctrl      <= '0;
      pend      <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (stage_load) begin
        prd_live <= prd_stage;
        cmp_live <= cmp_stage;
      end
      if (wr_en) begin
        case (sel)
          SEL_PRD_LIVE:  prd_live  <= reg_wdata;
          SEL_CMP_LIVE:  cmp_live  <= reg_wdata;
          SEL_PRD_STAGE: prd_stage <= reg_wdata;
          SEL_CMP_STAGE: cmp_stage <= reg_wdata;
          SEL_CONTROL:   ctrl      <= reg_wdata[CTRL_W-1:0];
          default:       ;
        endcase
      end
      if (stage_wr)        pend <= 1'b1;
      else if (stage_load) pend <= 1'b0;
      if (rd_en) reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/apwm_counter.sv
module apwm_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [DATA_W-1:0] prd,
  output logic [DATA_W-1:0] cnt,
  output logic              wrap
);
  function automatic logic at_end(input logic [DATA_W-1:0] c,
                                  input logic [DATA_W-1:0] p);
    return c >= p;
  endfunction

  assign wrap = run && at_end(cnt, prd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (wrap) cnt <= '0;
    else if (run)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/apwm_outstage.sv
module apwm_outstage #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode,
  input  logic              pol_low,
  input  logic [DATA_W-1:0] cnt,
  input  logic [DATA_W-1:0] cmp,
  output logic              pwm_out
);
  function automatic logic drive_level(input logic [DATA_W-1:0] c,
                                       input logic [DATA_W-1:0] k,
                                       input logic              inv);
    return (c < k) ^ inv;
  endfunction

  logic level;
  assign level = mode && drive_level(cnt, cmp, pol_low);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_out <= 1'b0;
    else        pwm_out <= level;
  end
endmodule

// File: rtl/apwm_shadow_gen.sv
module apwm_shadow_gen import apwm_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CTRL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              pwm_out
);
  logic [DATA_W-1:0] prd_live, cmp_live, cnt;
  logic [CTRL_W-1:0] ctrl;
  logic              pend, stage_load, wrap;

  apwm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wrap(wrap), .prd_live(prd_live), .cmp_live(cmp_live), .ctrl(ctrl),
    .pend(pend), .stage_load(stage_load)
  );

  apwm_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctrl[CB_RUN]), .prd(prd_live),
    .cnt(cnt), .wrap(wrap)
  );

  apwm_outstage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .mode(ctrl[CB_MODE]), .pol_low(ctrl[CB_POL_LOW]),
    .cnt(cnt), .cmp(cmp_live), .pwm_out(pwm_out)
  );
endmodule

// File: rtl/apwm_shadow_gen_chk.sv
module apwm_shadow_gen_chk import apwm_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CTRL_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_valid,
  input logic              reg_write,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              pwm_out,
  input logic              wrap,
  input logic              pend,
  input logic [DATA_W-1:0] cnt,
  input logic [DATA_W-1:0] prd_live,
  input logic [DATA_W-1:0] cmp_live,
  input logic [CTRL_W-1:0] ctrl
);
  reg_sel_e sel;
  logic     wr_prd_live, wr_cmp_live, wr_stage;
  assign sel         = decode_offset(16'(reg_addr));
  assign wr_prd_live = reg_valid && reg_write && sel == SEL_PRD_LIVE;
  assign wr_cmp_live = reg_valid && reg_write && sel == SEL_CMP_LIVE;
  assign wr_stage    = reg_valid && reg_write &&
                       (sel == SEL_PRD_STAGE || sel == SEL_CMP_STAGE);

  always @(posedge clk) begin
    if (!rst_n) assert_reset_low_R1: assert (pwm_out == 1'b0);
  end

  assert_wrap_to_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt == '0);

  assert_hold_when_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[CB_RUN] |=> cnt == $past(cnt));

  assert_mode_forces_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[CB_MODE] |=> !pwm_out);

  assert_zero_cmp_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[CB_MODE] && cmp_live == '0) |=> pwm_out == $past(ctrl[CB_POL_LOW]));

  assert_prd_only_at_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap && !wr_prd_live) |=> $stable(prd_live));

  assert_cmp_only_at_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap && !wr_cmp_live) |=> $stable(cmp_live));

  assert_pend_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !wr_stage) |=> !pend);

  assert_no_pend_no_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && !wr_prd_live) |=> $stable(prd_live));
endmodule

bind apwm_shadow_gen apwm_shadow_gen_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
  .reg_addr(reg_addr), .pwm_out(pwm_out), .wrap(wrap), .pend(pend),
  .cnt(cnt), .prd_live(prd_live), .cmp_live(cmp_live), .ctrl(ctrl)
);

// File: tb/apwm_shadow_gen_tb.sv
module apwm_shadow_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_valid = 1'b0;
  logic        reg_write = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pwm_out;

  int n_checks = 0;
  int n_errs   = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } sb_item_t;
  sb_item_t sb_q[$];
  logic     mon_due = 1'b0;

  localparam logic [31:0] C_RUN  = 32'h0010;
  localparam logic [31:0] C_MODE = 32'h0200;
  localparam logic [31:0] C_POL  = 32'h0400;
  localparam logic [31:0] C_SYNC = 32'h00C0;

  always #2 clk = ~clk;

  apwm_shadow_gen u_dut (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pwm_out(pwm_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) mon_due <= reg_valid && !reg_write;

  always @(negedge clk) begin
    if (mon_due && sb_q.size() > 0) begin
      sb_item_t it;
      it = sb_q.pop_front();
      check(it.tag, reg_rdata, it.exp);
    end
  end

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic reg_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    sb_item_t it;
    @(negedge clk);
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic measure(input int n, output int highs, output int rises);
    logic prev;
    highs = 0; rises = 0;
    @(negedge clk);
    prev = pwm_out;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) highs++;
      if (pwm_out && !prev) rises++;
      prev = pwm_out;
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_checks++; n_errs++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int h, r;
    settle(3);
    check("R1 output low in reset", 32'(pwm_out), 0);
    rst_n = 1'b1;
    settle(2);
    // R1 all registers clear after reset
    reg_rd(8'h08, 0, "R1 live period");
    reg_rd(8'h0C, 0, "R1 live compare");
    reg_rd(8'h10, 0, "R1 staged period");
    reg_rd(8'h14, 0, "R1 staged compare");
    reg_rd(8'h2A, 0, "R1 control");
    // R2 unmapped offset
    reg_rd(8'h04, 0, "R2 unmapped reads zero");

    // R3, R5: P=9, C=3, normal polarity
    reg_wr(8'h08, 9);
    reg_wr(8'h0C, 3);
    reg_wr(8'h2A, C_MODE | C_RUN);
    reg_rd(8'h08, 9, "R2 live period readback");
    reg_rd(8'h2A, C_MODE | C_RUN, "R2 control readback");
    settle(12);
    measure(50, h, r);
    check("R5 high cycles P9 C3", h, 15);
    check("R3 periods in 50 cycles", r, 5);

    // R6 inverted polarity
    reg_wr(8'h2A, C_MODE | C_RUN | C_POL);
    settle(12);
    measure(50, h, r);
    check("R6 inverted high cycles", h, 35);

    // R7 mode clear forces low
    reg_wr(8'h2A, C_RUN | C_POL);
    settle(3);
    measure(30, h, r);
    check("R7 mode off gives low", h, 0);

    // R8 compare extremes, R11 live compare while running
    reg_wr(8'h2A, C_MODE | C_RUN);
    reg_wr(8'h0C, 0);
    settle(12);
    measure(50, h, r);
    check("R8 compare zero constant low", h, 0);
    reg_wr(8'h0C, 12);
    settle(12);
    measure(50, h, r);
    check("R8 compare above period constant high", h, 50);

    // R4 stopped counter freezes output
    reg_wr(8'h0C, 3);
    reg_wr(8'h2A, C_MODE);
    settle(5);
    measure(20, h, r);
    check("R4 no toggles while stopped", r, 0);
    check("R4 level frozen while stopped", 32'(h == 0 || h == 20), 1);

    // R9 staged writes wait for a wrap
    reg_wr(8'h10, 4);
    reg_wr(8'h14, 2);
    reg_rd(8'h08, 9, "R9 live period untouched before wrap");
    reg_rd(8'h0C, 3, "R9 live compare untouched before wrap");
    reg_rd(8'h10, 4, "R2 staged period readback");
    reg_rd(8'h14, 2, "R2 staged compare readback");
    reg_wr(8'h2A, C_MODE | C_RUN);
    settle(20);
    reg_rd(8'h08, 4, "R9 live period after wrap");
    reg_rd(8'h0C, 2, "R9 live compare after wrap");
    measure(50, h, r);
    check("R9 staged high cycles", h, 20);
    check("R9 staged period count", r, 10);

    // R11 live writes while running, R10 no repeat transfer
    reg_wr(8'h08, 7);
    reg_wr(8'h0C, 1);
    settle(40);
    reg_rd(8'h08, 7, "R10 live period kept across wraps");
    reg_rd(8'h0C, 1, "R10 live compare kept across wraps");
    settle(10);
    measure(48, h, r);
    check("R11 direct write high cycles", h, 6);
    check("R11 direct write period count", r, 6);

    // R12 sync-disable field has no effect
    reg_wr(8'h2A, C_MODE | C_RUN | C_SYNC);
    reg_rd(8'h2A, C_MODE | C_RUN | C_SYNC, "R12 sync field readback");
    settle(10);
    measure(48, h, r);
    check("R12 waveform unchanged by sync field", h, 6);

    settle(4);
    finish_run();
  end
endmodule